// File: doc/BRIEF.md
# Multistage Omega Switching Network

This block moves one word-wide packet from each of P input lines to the output line named by that packet's destination tag. P is a power of two and defaults to 8. The packets cross log2 P registered stages. Each stage first rewires its lines with a perfect shuffle: line i feeds line j, where j is i rotated left by one bit. It then passes them through a column of P/2 two-by-two switches. Each switch is set per packet from a single destination bit. Stage 0 uses the most significant bit, and each later stage uses the next bit toward the least significant end. A packet whose bit is 0 leaves on the upper output of its switch, and a packet whose bit is 1 leaves on the lower output.

The network is blocking: two packets can ask for the same switch output. When that happens the packet on the upper switch input goes through. The packet on the lower input is discarded, and a blocked flag is raised for the input line it came from. The blocked flags of one batch travel down the pipeline with that batch. They appear on the same cycle as the delivered packets, so a source can tell at once whether its packet was delivered. A new batch may enter on every cycle.

Top module: `omega_network`

## Requirements
- R1: While reset is high, and on the first cycle after it, every `out_vld` bit and every `blocked_o` bit is 0.
- R2: A batch presented on the inputs in the cycle before clock edge t appears on the outputs after edge t+log2 P−1, and not earlier. Each delivered lane carries its packet's payload unchanged in `out_data` and the packet's input line number in `out_src`.
- R3: A delivered packet leaves on the output line whose index equals its destination tag. Switch settings follow the destination bits, the most significant bit at stage 0, with upper-input-first arbitration.
- R4: A batch in which every source/destination pair differs in the same set of bit positions (dst = src XOR a constant mask) is delivered in full, with `blocked_o` all 0.
- R5: When two packets at one switch request the same output, the packet on the upper input (the even-numbered line after the shuffle) wins. The other packet is dropped, and `blocked_o` is set at its source index. With P=8, sources 2→7 and 6→4 collide: source 2 is delivered on line 7, and `blocked_o` = 8'b0100_0000.
- R6: An input whose valid bit is 0 never blocks another packet and is never delivered or flagged, whatever its destination tag.
- R7: For every batch, each valid input is either delivered exactly once or flagged blocked exactly once, never both.
- R8: Batches entered on consecutive cycles are routed independently, each reaching the outputs log2 P cycles after it entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | P | Per-line packet present |
| in_dst | input | P×log2 P | Per-line destination tag |
| in_data | input | P×W | Per-line payload |
| out_vld | output | P | Per-output-line packet delivered |
| out_src | output | P×log2 P | Input line the delivered packet came from |
| out_data | output | P×W | Payload of the delivered packet |
| blocked_o | output | P | Per-input-line flag: packet of this batch was dropped |

## Verification
The checker keeps its own shifted copy of the input valid bits. It therefore takes for granted that reset is asserted before the first batch, so that this copy and the stage registers start out empty together. The stimulus holds reset high from time zero and changes inputs only on falling edges. No assumption is made about the destination tags: patterns that collide, that repeat one destination, or that come from a pseudo-random generator are all legal. The stimulus deliberately includes them, next to conflict-free XOR permutations and lines with a tag set but the valid bit clear.

// File: rtl/omega_pkg.sv
`timescale 1ns/1ps
package omega_pkg;

    typedef enum logic {
        SW_PASS  = 1'b0,
        SW_CROSS = 1'b1
    } sw_mode_e;

    // Perfect-shuffle target: rotate an n-bit line number left by one.
    function automatic int shuffle_line(input int line, input int n);
        return ((line << 1) | (line >> (n - 1))) & ((1 << n) - 1);
    endfunction

endpackage

// File: rtl/omega_switch.sv
`timescale 1ns/1ps
module omega_switch #(
    parameter int N      = 3,
    parameter int W      = 8,
    parameter int BITPOS = 2
) (
    input  logic [2*N+W:0] up_i,
    input  logic [2*N+W:0] lo_i,
    output logic [2*N+W:0] up_o,
    output logic [2*N+W:0] lo_o,
    output logic           drop_o,
    output logic [N-1:0]   drop_src_o
);
    import omega_pkg::*;

    typedef struct packed {
        logic         vld;
        logic [N-1:0] dst;
        logic [N-1:0] src;
        logic [W-1:0] data;
    } lane_t;

    lane_t    up, lo, lo_kept;
    logic     ub, lb, clash;
    sw_mode_e mode;

    assign up = up_i;
    assign lo = lo_i;
    assign ub = up.dst[BITPOS];
    assign lb = lo.dst[BITPOS];

    always_comb begin
        clash   = up.vld && lo.vld && (ub == lb);
        lo_kept = clash ? '0 : lo;
        if (up.vld) mode = ub ? SW_CROSS : SW_PASS;
        else        mode = lb ? SW_PASS  : SW_CROSS;
        if (mode == SW_PASS) begin
            up_o = up;
            lo_o = lo_kept;
        end else begin
            up_o = lo_kept;
            lo_o = up;
        end
    end

    assign drop_o     = clash;
    assign drop_src_o = lo.src;

endmodule

// File: rtl/omega_stage.sv
`timescale 1ns/1ps
module omega_stage #(
    parameter int P     = 8,
    parameter int N     = 3,
    parameter int W     = 8,
    parameter int STAGE = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [P-1:0][2*N+W:0]     lane_i,
    input  logic [P-1:0]              blk_i,
    output logic [P-1:0][2*N+W:0]     lane_o,
    output logic [P-1:0]              blk_o
);
    import omega_pkg::*;

    localparam int SWITCHES = P / 2;

    logic [P-1:0][2*N+W:0]  shuf, sw_out;
    logic [SWITCHES-1:0]    drop;
    logic [SWITCHES-1:0][N-1:0] drop_src;
    logic [P-1:0]           blk_next;

    for (genvar i = 0; i < P; i++) begin : g_shuffle
        assign shuf[shuffle_line(i, N)] = lane_i[i];
    end

    for (genvar k = 0; k < SWITCHES; k++) begin : g_switch
        omega_switch #(
            .N      (N),
            .W      (W),
            .BITPOS (N - 1 - STAGE)
        ) u_sw (
            .up_i       (shuf[2*k]),
            .lo_i       (shuf[2*k+1]),
            .up_o       (sw_out[2*k]),
            .lo_o       (sw_out[2*k+1]),
            .drop_o     (drop[k]),
            .drop_src_o (drop_src[k])
        );
    end

    always_comb begin
        blk_next = blk_i;
        for (int k = 0; k < SWITCHES; k++) begin
            if (drop[k]) blk_next[drop_src[k]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_o <= '0;
            blk_o  <= '0;
        end else begin
            lane_o <= sw_out;
            blk_o  <= blk_next;
        end
    end

endmodule

// File: rtl/omega_network.sv
`timescale 1ns/1ps
module omega_network #(
    parameter int P = 8,
    parameter int W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [P-1:0]                 in_vld,
    input  logic [P-1:0][$clog2(P)-1:0]  in_dst,
    input  logic [P-1:0][W-1:0]          in_data,
    output logic [P-1:0]                 out_vld,
    output logic [P-1:0][$clog2(P)-1:0]  out_src,
    output logic [P-1:0][W-1:0]          out_data,
    output logic [P-1:0]                 blocked_o
);
    localparam int N  = $clog2(P);
    localparam int LW = 1 + 2*N + W;

    logic [N:0][P-1:0][LW-1:0] st_lane;
    logic [N:0][P-1:0]         st_blk;

    for (genvar i = 0; i < P; i++) begin : g_inject
        localparam logic [N-1:0] SRC = N'(i);
        assign st_lane[0][i] = {in_vld[i], in_dst[i], SRC, in_data[i]};
    end
    assign st_blk[0] = '0;

    for (genvar s = 0; s < N; s++) begin : g_stage
        omega_stage #(
            .P     (P),
            .N     (N),
            .W     (W),
            .STAGE (s)
        ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .lane_i (st_lane[s]),
            .blk_i  (st_blk[s]),
            .lane_o (st_lane[s+1]),
            .blk_o  (st_blk[s+1])
        );
    end

    for (genvar j = 0; j < P; j++) begin : g_out
        assign out_vld[j]  = st_lane[N][j][LW-1];
        assign out_src[j]  = st_lane[N][j][N+W-1 -: N];
        assign out_data[j] = st_lane[N][j][W-1:0];
    end
    assign blocked_o = st_blk[N];

endmodule

module omega_network_chk #(
    parameter int P = 8,
    parameter int N = 3,
    parameter int W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [P-1:0]             in_vld,
    input logic [P-1:0]             out_vld,
    input logic [P-1:0][N-1:0]      out_src,
    input logic [P-1:0]             blocked_o,
    input logic [P-1:0][2*N+W:0]    last_lane
);
    localparam int LW = 1 + 2*N + W;

    logic [N-1:0][P-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist[0] <= in_vld;
            for (int k = 1; k < N; k++) hist[k] <= hist[k-1];
        end
    end

    // R1: outputs are quiet right after reset
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_vld == '0 && blocked_o == '0));

    // R7: delivered plus blocked equals valid inputs of the batch
    assert_conserve_R7: assert property (@(posedge clk) disable iff (rst)
        ($countones(out_vld) + $countones(blocked_o)) == $countones(hist[N-1]));

    // R6: only sources that were valid can be flagged
    assert_block_valid_only_R6: assert property (@(posedge clk) disable iff (rst)
        (blocked_o & ~hist[N-1]) == '0);

    for (genvar j = 0; j < P; j++) begin : g_lane
        localparam logic [N-1:0] LINE = N'(j);

        // R3: delivered lane index equals destination tag
        assert_dest_match_R3: assert property (@(posedge clk) disable iff (rst)
            out_vld[j] |-> (last_lane[j][LW-2 -: N] == LINE));

        // R7: a delivered source was valid and is not also flagged
        assert_not_both_R7: assert property (@(posedge clk) disable iff (rst)
            out_vld[j] |-> (hist[N-1][out_src[j]] && !blocked_o[out_src[j]]));
    end

endmodule

bind omega_network omega_network_chk #(.P(P), .N(N), .W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .out_vld   (out_vld),
    .out_src   (out_src),
    .blocked_o (blocked_o),
    .last_lane (st_lane[N])
);

// File: tb/omega_network_bench.sv
`timescale 1ns/1ps
module omega_network_bench;
    localparam int P = 8;
    localparam int W = 8;
    localparam int N = $clog2(P);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [P-1:0]        in_vld = '0;
    logic [P-1:0][N-1:0] in_dst = '0;
    logic [P-1:0][W-1:0] in_data = '0;
    logic [P-1:0]        out_vld;
    logic [P-1:0][N-1:0] out_src;
    logic [P-1:0][W-1:0] out_data;
    logic [P-1:0]        blocked_o;

    int tests = 0;
    int fails = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    omega_network #(.P(P), .W(W)) u_omega_network (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_dst(in_dst), .in_data(in_data),
        .out_vld(out_vld), .out_src(out_src), .out_data(out_data), .blocked_o(blocked_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int shuf(input int x);
        return ((x << 1) | (x >> (N - 1))) & ((1 << N) - 1);
    endfunction

    // Bit-by-bit routing of one batch, upper line first at every switch.
    task automatic model(input logic [P-1:0] v, input logic [P-1:0][N-1:0] d,
                         output logic [P-1:0] ev, output logic [P-1:0][N-1:0] es,
                         output logic [P-1:0] eb);
        int pos [P];
        bit alive [P];
        int occ [P];
        ev = '0; es = '0; eb = '0;
        for (int i = 0; i < P; i++) begin pos[i] = i; alive[i] = v[i]; end
        for (int s = 0; s < N; s++) begin
            for (int l = 0; l < P; l++) occ[l] = -1;
            for (int i = 0; i < P; i++) if (alive[i]) occ[shuf(pos[i])] = i;
            for (int k = 0; k < P/2; k++) begin
                int u = occ[2*k];
                int w = occ[2*k+1];
                int bu = 0;
                if (u >= 0) begin
                    bu = d[u][N-1-s];
                    pos[u] = 2*k + bu;
                end
                if (w >= 0) begin
                    if (u >= 0 && d[w][N-1-s] == bu) begin
                        alive[w] = 1'b0;
                        eb[w] = 1'b1;
                    end else begin
                        pos[w] = 2*k + d[w][N-1-s];
                    end
                end
            end
        end
        for (int i = 0; i < P; i++) if (alive[i]) begin
            ev[pos[i]] = 1'b1;
            es[pos[i]] = N'(i);
        end
    endtask

    task automatic drive(input logic [P-1:0] v, input logic [P-1:0][N-1:0] d,
                         input logic [W-1:0] base);
        in_vld = v;
        in_dst = d;
        for (int i = 0; i < P; i++) in_data[i] = base + W'(i);
    endtask

    task automatic idle();
        in_vld = '0;
        in_dst = '0;
        in_data = '0;
    endtask

    task automatic check_batch(input string tag, input logic [P-1:0] v,
                               input logic [P-1:0][N-1:0] d, input logic [W-1:0] base);
        logic [P-1:0] ev, eb;
        logic [P-1:0][N-1:0] es;
        model(v, d, ev, es, eb);
        chk(out_vld == ev, "R3", {tag, " out_vld"}, int'(out_vld), int'(ev));
        chk(blocked_o == eb, "R5", {tag, " blocked_o"}, int'(blocked_o), int'(eb));
        chk($countones(out_vld) + $countones(blocked_o) == $countones(v), "R7",
            {tag, " conservation"}, $countones(out_vld) + $countones(blocked_o), $countones(v));
        for (int j = 0; j < P; j++) if (out_vld[j] && ev[j]) begin
            chk(out_src[j] == es[j], "R2", {tag, " out_src"}, int'(out_src[j]), int'(es[j]));
            chk(int'(d[out_src[j]]) == j, "R3", {tag, " dest tag"}, int'(d[out_src[j]]), j);
            chk(out_data[j] == base + W'(out_src[j]), "R2", {tag, " payload"},
                int'(out_data[j]), int'(base + W'(out_src[j])));
        end
    endtask

    // One batch: checks silence one cycle early, then the full result.
    task automatic run_batch(input string tag, input logic [P-1:0] v,
                             input logic [P-1:0][N-1:0] d, input logic [W-1:0] base);
        @(negedge clk); drive(v, d, base);
        @(posedge clk);
        @(negedge clk); idle();
        repeat (N - 2) @(posedge clk);
        @(negedge clk);
        chk(out_vld == '0, "R2", {tag, " early out_vld"}, int'(out_vld), 0);
        @(posedge clk);
        @(negedge clk);
        check_batch(tag, v, d, base);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_vld == '0, "R1", "reset out_vld", int'(out_vld), 0);
        chk(blocked_o == '0, "R1", "reset blocked_o", int'(blocked_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_vld == '0 && blocked_o == '0, "R1", "after reset",
            int'({out_vld, blocked_o}), 0);
    endtask

    task automatic t_xor_perms();
        for (int m = 0; m < P; m++) begin
            logic [P-1:0][N-1:0] d;
            for (int i = 0; i < P; i++) d[i] = N'(i ^ m);
            run_batch("R4 xor perm", '1, d, W'(8'h10 + m));
            chk(blocked_o == '0 && out_vld == '1, "R4", "xor perm full delivery",
                int'({out_vld, blocked_o}), int'({{P{1'b1}}, {P{1'b0}}}));
        end
    endtask

    task automatic t_known_clash();
        logic [P-1:0][N-1:0] d = '0;
        logic [P-1:0] v = '0;
        v[2] = 1'b1; d[2] = 3'd7;
        v[6] = 1'b1; d[6] = 3'd4;
        run_batch("R5 clash", v, d, 8'h40);
        chk(blocked_o == 8'b0100_0000, "R5", "clash flag", int'(blocked_o), 8'h40);
        chk(out_vld == 8'b1000_0000 && out_src[7] == 3'd2, "R5", "clash winner line 7",
            int'({out_vld, out_src[7]}), int'({8'h80, 3'd2}));
    endtask

    task automatic t_invalid_ignored();
        logic [P-1:0][N-1:0] d = '0;
        logic [P-1:0] v = '0;
        d[2] = 3'd7;
        v[6] = 1'b1; d[6] = 3'd4;
        run_batch("R6 invalid", v, d, 8'h50);
        chk(out_vld == 8'b0001_0000 && out_src[4] == 3'd6, "R6", "lone packet line 4",
            int'({out_vld, out_src[4]}), int'({8'h10, 3'd6}));
        chk(blocked_o == '0, "R6", "invalid causes no block", int'(blocked_o), 0);
    endtask

    task automatic t_hotspot();
        logic [P-1:0][N-1:0] d = '0;
        run_batch("R7 hotspot", '1, d, 8'h60);
        chk(out_vld == 8'b0000_0001, "R7", "one survivor", int'(out_vld), 1);
        chk($countones(blocked_o) == P - 1, "R7", "rest blocked", $countones(blocked_o), P - 1);
    endtask

    task automatic t_back_to_back();
        logic [P-1:0][N-1:0] da, db;
        logic [P-1:0] va = 8'b1010_0110;
        logic [P-1:0] vb = 8'b0111_1001;
        for (int i = 0; i < P; i++) begin
            da[i] = N'(P - 1 - i);
            db[i] = N'((i * 3 + 1) % P);
        end
        @(negedge clk); drive(va, da, 8'h70);
        @(posedge clk);
        @(negedge clk); drive(vb, db, 8'h90);
        @(posedge clk);
        @(negedge clk); idle();
        repeat (N - 2) @(posedge clk);
        @(negedge clk);
        check_batch("R8 first", va, da, 8'h70);
        @(posedge clk);
        @(negedge clk);
        check_batch("R8 second", vb, db, 8'h90);
        @(posedge clk);
        @(negedge clk);
        chk(out_vld == '0 && blocked_o == '0, "R8", "pipe drained",
            int'({out_vld, blocked_o}), 0);
    endtask

    task automatic t_random();
        for (int r = 0; r < 40; r++) begin
            logic [P-1:0][N-1:0] d;
            logic [P-1:0] v;
            for (int i = 0; i < P; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                d[i] = lfsr[N-1:0];
                v[i] = lfsr[7] | lfsr[9];
            end
            run_batch("R3 random", v, d, W'(r * 5));
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL R2 watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_xor_perms();
        t_known_clash();
        t_invalid_ignored();
        t_hotspot();
        t_back_to_back();
        t_random();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule